// File: doc/BRIEF.md
# Multi-Window Echo Cancelling Filter

This block removes loop-back echoes from the complex baseband stream of an on-channel repeater. Each incoming I/Q sample enters one long shared shift-register line that spans the whole echo search range. Several short complex FIR filters ("windows") each read a contiguous group of taps from that line. The start of the group is set by a per-window offset, which places the window at a chosen echo delay. The estimated echo is the sum of the outputs of all enabled windows. It is scaled and subtracted from the current sample, and the saturated difference is the stream that gets retransmitted.

The line length and the taps per window come from the sample rate and two delay spans given as parameters. The defaults are a 60 us search range and a 5 us window. Channel estimation and adaptation sit outside the block. Coefficients arrive through a write port that addresses one window and one tap. A write takes effect while samples keep flowing. The pipeline latency is fixed at `mwec_pkg::LATENCY` (2 cycles).

Top module: `mw_echo_canceller`

## Requirements
- R1: After reset, `valid_o` is low, both outputs are zero and every coefficient is zero. Samples therefore pass through unchanged until coefficients are written.
- R2: Each cycle with `valid_i` high produces exactly one cycle of `valid_o`, two cycles later. Between results, `out_re_o` and `out_im_o` hold their last value.
- R3: For sample x[n], out = sat(x[n] - floor(E / 2^COEF_FRAC)). E is the sum, over enabled windows w and taps k, of the complex product h_w[k] * x[n - off_w - k] = (a+jb)(c+jd) = (ac-bd) + j(ad+bc). Coefficients are signed, so 2^COEF_FRAC (1024 by default) is unity. Samples from before reset count as zero.
- R4: The offset of window w is given in samples and sits at bits [w*OFFW +: OFFW] of `win_off_i`. Offset 0 makes tap 0 use the current sample.
- R5: LINE_LEN = ceil(SAMPLE_KHZ*SPAN_NS/1e6) and TAPS = ceil(SAMPLE_KHZ*WIN_NS/1e6). Any offset above LINE_LEN-TAPS behaves exactly like LINE_LEN-TAPS.
- R6: A window whose bit in `win_en_i` is low contributes zero to E, whatever its coefficients are.
- R7: The echoes of all enabled windows add up, each window at its own offset.
- R8: A coefficient write (`cw_en_i`, `cw_win_i`, `cw_tap_i`, `cw_re_i`, `cw_im_i`) applies to the sample presented in the same cycle and to all later samples. Samples presented earlier are not affected. The data stream is never stalled.
- R9: A write whose window index is at least NUM_WIN, or whose tap index is at least TAPS, changes no coefficient. A write changes no tap other than the one it addresses.
- R10: Results outside the DW-bit signed range clamp to the largest positive or most negative value.
- R11: Offsets and enables are captured together with their sample. Changing them on the following cycle does not affect a sample already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| in_re_i | input | DW | Received sample, real part |
| in_im_i | input | DW | Received sample, imaginary part |
| win_en_i | input | NUM_WIN | Per-window enable |
| win_off_i | input | NUM_WIN*OFFW | Per-window delay offset, in samples |
| cw_en_i | input | 1 | Coefficient write strobe |
| cw_win_i | input | WINW | Coefficient write window index |
| cw_tap_i | input | TAPW | Coefficient write tap index |
| cw_re_i | input | CW | Coefficient real part |
| cw_im_i | input | CW | Coefficient imaginary part |
| valid_o | output | 1 | Output sample strobe |
| out_re_o | output | DW | Cancelled sample, real part |
| out_im_o | output | DW | Cancelled sample, imaginary part |

## Verification
The filter is driven with four kinds of input:
- Zero coefficients separate plain pass-through from any echo path.
- A single impulse through a unity tap shows the exact delay an offset selects.
- Random complex data against random complex coefficients exposes swapped or mis-signed cross terms and wrong scaling.
- Full-scale inputs against a negated unity tap drive both saturation limits.

Back-to-back streams in which coefficients, offsets and enables change every cycle show whether each control is applied to the right sample. Offsets past the end of the line, and out-of-range write indices, probe the clamp and the ignore rules.

// File: rtl/mwec_pkg.sv
package mwec_pkg;
  localparam int LATENCY = 2;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/mwec_delay_line.sv
module mwec_delay_line #(
  parameter int LEN = 64,
  parameter int DW  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic [DW-1:0]           din_re_i,
  input  logic [DW-1:0]           din_im_i,
  output logic [LEN-1:0][DW-1:0]  line_re_o,
  output logic [LEN-1:0][DW-1:0]  line_im_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_re_o <= '0;
      line_im_o <= '0;
    end else if (shift_i) begin
      line_re_o[0] <= din_re_i;
      line_im_o[0] <= din_im_i;
      for (int i = 1; i < LEN; i++) begin
        line_re_o[i] <= line_re_o[i-1];
        line_im_o[i] <= line_im_o[i-1];
      end
    end
  end
endmodule

// File: rtl/mwec_window.sv
module mwec_window #(
  parameter int LEN  = 64,
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int OFFW = 6,
  parameter int TAPW = 2,
  parameter int ACCW = 28
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LEN-1:0][DW-1:0] line_re_i,
  input  logic [LEN-1:0][DW-1:0] line_im_i,
  input  logic [OFFW-1:0]        off_i,
  input  logic                   en_i,
  input  logic                   cw_sel_i,
  input  logic [TAPW-1:0]        cw_tap_i,
  input  logic [CW-1:0]          cw_re_i,
  input  logic [CW-1:0]          cw_im_i,
  output logic signed [ACCW-1:0] acc_re_o,
  output logic signed [ACCW-1:0] acc_im_o
);
  localparam int PW      = DW + CW + 1;
  localparam int MAX_OFF = LEN - TAPS;

  logic signed [CW-1:0] coef_re_q [TAPS];
  logic signed [CW-1:0] coef_im_q [TAPS];
  logic signed [PW-1:0] prod_re [TAPS];
  logic signed [PW-1:0] prod_im [TAPS];
  logic [OFFW-1:0]      eff_off;
  logic signed [ACCW-1:0] sum_re, sum_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) begin
        coef_re_q[k] <= '0;
        coef_im_q[k] <= '0;
      end
    end else if (cw_sel_i && int'(cw_tap_i) < TAPS) begin
      coef_re_q[cw_tap_i] <= cw_re_i;
      coef_im_q[cw_tap_i] <= cw_im_i;
    end
  end

  // offsets past the end of the line pin the window to the last legal place
  assign eff_off = (int'(off_i) > MAX_OFF) ? OFFW'(MAX_OFF) : off_i;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [OFFW-1:0]      idx;
    logic signed [DW-1:0] a_re, a_im;
    logic signed [PW-1:0] ax_re, ax_im, cx_re, cx_im;
    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;

    assign idx   = eff_off + OFFW'(k);
    assign a_re  = line_re_i[idx];
    assign a_im  = line_im_i[idx];
    assign ax_re = {{(PW-DW){a_re[DW-1]}}, a_re};
    assign ax_im = {{(PW-DW){a_im[DW-1]}}, a_im};
    assign cx_re = {{(PW-CW){coef_re_q[k][CW-1]}}, coef_re_q[k]};
    assign cx_im = {{(PW-CW){coef_im_q[k][CW-1]}}, coef_im_q[k]};
    assign m_rr  = ax_re * cx_re;
    assign m_ii  = ax_im * cx_im;
    assign m_ri  = ax_re * cx_im;
    assign m_ir  = ax_im * cx_re;
    assign prod_re[k] = m_rr - m_ii;
    assign prod_im[k] = m_ri + m_ir;

    AST_TAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cw_sel_i && int'(cw_tap_i) == k) |=> ($stable(coef_re_q[k]) && $stable(coef_im_q[k]))); // R9
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_re = sum_re + {{(ACCW-PW){prod_re[k][PW-1]}}, prod_re[k]};
      sum_im = sum_im + {{(ACCW-PW){prod_im[k][PW-1]}}, prod_im[k]};
    end
  end

  assign acc_re_o = en_i ? sum_re : '0;
  assign acc_im_o = en_i ? sum_im : '0;
endmodule

// File: rtl/mwec_combine.sv
module mwec_combine #(
  parameter int NUM_WIN   = 4,
  parameter int DW        = 12,
  parameter int ACCW      = 28,
  parameter int COEF_FRAC = 10
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            v_i,
  input  logic [DW-1:0]                   x_re_i,
  input  logic [DW-1:0]                   x_im_i,
  input  logic [NUM_WIN-1:0][ACCW-1:0]    win_re_i,
  input  logic [NUM_WIN-1:0][ACCW-1:0]    win_im_i,
  output logic                            valid_o,
  output logic [DW-1:0]                   out_re_o,
  output logic [DW-1:0]                   out_im_o
);
  localparam int SUMW = ACCW + $clog2(NUM_WIN + 1);
  localparam int DFW  = SUMW + 1;

  logic signed [SUMW-1:0] sum_re, sum_im, echo_re, echo_im;
  logic signed [DFW-1:0]  diff_re, diff_im;

  function automatic logic [DW-1:0] sat(input logic signed [DFW-1:0] v);
    logic signed [DFW-1:0] hi, lo;
    hi = DFW'(2 ** (DW - 1) - 1);
    lo = -hi - DFW'(1);
    if (v > hi)      return hi[DW-1:0];
    else if (v < lo) return lo[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      sum_re = sum_re + {{(SUMW-ACCW){win_re_i[w][ACCW-1]}}, win_re_i[w]};
      sum_im = sum_im + {{(SUMW-ACCW){win_im_i[w][ACCW-1]}}, win_im_i[w]};
    end
  end

  assign echo_re = sum_re >>> COEF_FRAC;
  assign echo_im = sum_im >>> COEF_FRAC;
  assign diff_re = {{(DFW-DW){x_re_i[DW-1]}}, x_re_i} - {echo_re[SUMW-1], echo_re};
  assign diff_im = {{(DFW-DW){x_im_i[DW-1]}}, x_im_i} - {echo_im[SUMW-1], echo_im};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      out_re_o <= '0;
      out_im_o <= '0;
    end else begin
      valid_o <= v_i;
      if (v_i) begin
        out_re_o <= sat(diff_re);
        out_im_o <= sat(diff_im);
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> ($stable(out_re_o) && $stable(out_im_o))); // R2
endmodule

// File: rtl/mw_echo_canceller.sv
module mw_echo_canceller
  import mwec_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int SAMPLE_KHZ = 9143,
  parameter int SPAN_NS    = 60000,
  parameter int WIN_NS     = 5000,
  parameter int DW         = 12,
  parameter int CW         = 12,
  parameter int COEF_FRAC  = CW - 2,
  localparam int LINE_LEN  = ceil_div(SAMPLE_KHZ * SPAN_NS, 1000000),
  localparam int TAPS      = ceil_div(SAMPLE_KHZ * WIN_NS, 1000000),
  localparam int OFFW      = $clog2(LINE_LEN),
  localparam int TAPW      = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int WINW      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [DW-1:0]           in_re_i,
  input  logic [DW-1:0]           in_im_i,
  input  logic [NUM_WIN-1:0]      win_en_i,
  input  logic [NUM_WIN*OFFW-1:0] win_off_i,
  input  logic                    cw_en_i,
  input  logic [WINW-1:0]         cw_win_i,
  input  logic [TAPW-1:0]         cw_tap_i,
  input  logic [CW-1:0]           cw_re_i,
  input  logic [CW-1:0]           cw_im_i,
  output logic                    valid_o,
  output logic [DW-1:0]           out_re_o,
  output logic [DW-1:0]           out_im_o
);
  localparam int ACCW = DW + CW + 1 + $clog2(TAPS + 1);

  logic                         v1_q;
  logic [DW-1:0]                x_re_q, x_im_q;
  logic [NUM_WIN*OFFW-1:0]      off_q;
  logic [NUM_WIN-1:0]           en_q;
  logic [LINE_LEN-1:0][DW-1:0]  line_re, line_im;
  logic [NUM_WIN-1:0][ACCW-1:0] win_re, win_im;

  // stage 1: sample enters the line; its controls travel with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      x_re_q <= '0;
      x_im_q <= '0;
      off_q  <= '0;
      en_q   <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        x_re_q <= in_re_i;
        x_im_q <= in_im_i;
        off_q  <= win_off_i;
        en_q   <= win_en_i;
      end
    end
  end

  mwec_delay_line #(.LEN(LINE_LEN), .DW(DW)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (valid_i),
    .din_re_i (in_re_i),
    .din_im_i (in_im_i),
    .line_re_o(line_re),
    .line_im_o(line_im)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = cw_en_i && (int'(cw_win_i) == w);

    mwec_window #(
      .LEN(LINE_LEN), .TAPS(TAPS), .DW(DW), .CW(CW),
      .OFFW(OFFW), .TAPW(TAPW), .ACCW(ACCW)
    ) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_re_i(line_re),
      .line_im_i(line_im),
      .off_i    (off_q[w*OFFW +: OFFW]),
      .en_i     (en_q[w]),
      .cw_sel_i (sel),
      .cw_tap_i (cw_tap_i),
      .cw_re_i  (cw_re_i),
      .cw_im_i  (cw_im_i),
      .acc_re_o (win_re[w]),
      .acc_im_o (win_im[w])
    );
  end

  mwec_combine #(
    .NUM_WIN(NUM_WIN), .DW(DW), .ACCW(ACCW), .COEF_FRAC(COEF_FRAC)
  ) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .v_i     (v1_q),
    .x_re_i  (x_re_q),
    .x_im_i  (x_im_q),
    .win_re_i(win_re),
    .win_im_i(win_im),
    .valid_o (valid_o),
    .out_re_o(out_re_o),
    .out_im_o(out_im_o)
  );

  // cycles since reset, so $past never reaches into reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (valid_o == $past(valid_i, LATENCY))); // R2

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(valid_i && win_en_i == '0, LATENCY))
      |-> (out_re_o == $past(in_re_i, LATENCY) && out_im_o == $past(in_im_i, LATENCY))); // R6
endmodule

// File: tb/sim_mw_echo_canceller.sv
module sim_mw_echo_canceller;
  localparam int NW   = 3;
  localparam int DW   = 12;
  localparam int CW   = 12;
  localparam int FRAC = 10;
  localparam int LEN  = 60;
  localparam int TP   = 5;
  localparam int OFFW = 6;
  localparam int TAPW = 3;
  localparam int WINW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [NW-1:0] win_en = '0;
  logic [NW*OFFW-1:0] win_off = '0;
  logic cw_en = 1'b0;
  logic [WINW-1:0] cw_win = '0;
  logic [TAPW-1:0] cw_tap = '0;
  logic [CW-1:0] cw_re = '0, cw_im = '0;
  logic valid_o;
  logic signed [DW-1:0] out_re, out_im;

  always #10 clk = ~clk;

  mw_echo_canceller #(
    .NUM_WIN(NW), .SAMPLE_KHZ(1000), .SPAN_NS(60000), .WIN_NS(5000),
    .DW(DW), .CW(CW), .COEF_FRAC(FRAC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .in_re_i(in_re), .in_im_i(in_im),
    .win_en_i(win_en), .win_off_i(win_off),
    .cw_en_i(cw_en), .cw_win_i(cw_win), .cw_tap_i(cw_tap),
    .cw_re_i(cw_re), .cw_im_i(cw_im),
    .valid_o(valid_o), .out_re_o(out_re), .out_im_o(out_im)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int hist_re[LEN], hist_im[LEN];
  int c_re[NW][TP], c_im[NW][TP];
  int off_m[NW];
  bit en_m[NW];
  int q_re[$], q_im[$], q_cyc[$];
  string q_tag[$];
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic step(input bit v, input int re, input int im,
                      input bit w, input int win, input int tap, input int cre, input int cim);
    int er, ei, o, ar, ai;
    @(negedge clk);
    valid_i = v;
    in_re = re[DW-1:0];
    in_im = im[DW-1:0];
    for (int i = 0; i < NW; i++) begin
      win_en[i] = en_m[i];
      win_off[i*OFFW +: OFFW] = off_m[i][OFFW-1:0];
    end
    cw_en = w;
    cw_win = win[WINW-1:0];
    cw_tap = tap[TAPW-1:0];
    cw_re = cre[CW-1:0];
    cw_im = cim[CW-1:0];
    if (w && win < NW && tap < TP) begin
      c_re[win][tap] = cre;
      c_im[win][tap] = cim;
    end
    if (v) begin
      for (int d = LEN - 1; d > 0; d--) begin
        hist_re[d] = hist_re[d-1];
        hist_im[d] = hist_im[d-1];
      end
      hist_re[0] = re;
      hist_im[0] = im;
      er = 0;
      ei = 0;
      for (int i = 0; i < NW; i++) begin
        if (en_m[i]) begin
          o = (off_m[i] > LEN - TP) ? LEN - TP : off_m[i];
          for (int k = 0; k < TP; k++) begin
            ar = hist_re[o+k];
            ai = hist_im[o+k];
            er += ar * c_re[i][k] - ai * c_im[i][k];
            ei += ar * c_im[i][k] + ai * c_re[i][k];
          end
        end
      end
      er = er >>> FRAC;
      ei = ei >>> FRAC;
      q_re.push_back(clampv(re - er));
      q_im.push_back(clampv(im - ei));
      q_cyc.push_back(cyc + 2);
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int win, input int tap, input int cre, input int cim);
    step(0, 0, 0, 1, win, tap, cre, cim);
  endtask

  task automatic send(input int re, input int im);
    step(1, re, im, 0, 0, 0, 0, 0);
  endtask

  function automatic int rnd(input int amp);
    return int'($urandom_range(0, 2 * amp)) - amp;
  endfunction

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      if (q_re.size() == 0) begin
        chk("R2", 1, 0, "unexpected valid_o");
      end else begin
        string t;
        int er, ei, ec;
        er = q_re.pop_front();
        ei = q_im.pop_front();
        ec = q_cyc.pop_front();
        t = q_tag.pop_front();
        chk("R2", cyc, ec, "result cycle");
        chk(t, int'(out_re), er, "out_re");
        chk(t, int'(out_im), ei, "out_im");
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int hold_re, hold_im;
    for (int d = 0; d < LEN; d++) begin hist_re[d] = 0; hist_im[d] = 0; end
    for (int i = 0; i < NW; i++) begin
      off_m[i] = 0;
      en_m[i] = 0;
      for (int k = 0; k < TP; k++) begin c_re[i][k] = 0; c_im[i][k] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(valid_o), 0, "reset valid_o");
    chk("R1", int'(out_re), 0, "reset out_re");
    chk("R1", int'(out_im), 0, "reset out_im");
    rst_n = 1'b1;

    // R1: zero coefficients, all windows on: pass-through
    tag = "R1";
    for (int i = 0; i < NW; i++) begin en_m[i] = 1; off_m[i] = 4 * i; end
    for (int i = 0; i < 8; i++) send(rnd(1500), rnd(1500));
    idle(3);

    // R4: unity tap 0 at offset 3, impulse then random
    tag = "R4";
    en_m[0] = 1; en_m[1] = 0; en_m[2] = 0; off_m[0] = 3;
    wr(0, 0, 1024, 0);
    send(500, -300);
    for (int i = 0; i < 6; i++) send(0, 0);
    for (int i = 0; i < 10; i++) send(rnd(800), rnd(800));
    idle(3);

    // R3: random complex coefficients in window 1
    tag = "R3";
    en_m[0] = 0; en_m[1] = 1; off_m[1] = 10;
    for (int k = 0; k < TP; k++) wr(1, k, rnd(512), rnd(512));
    for (int i = 0; i < 30; i++) send(rnd(600), rnd(600));
    idle(3);

    // R6: window 1 keeps coefficients but is disabled
    tag = "R6";
    en_m[0] = 1; en_m[1] = 0;
    for (int i = 0; i < 15; i++) send(rnd(600), rnd(600));
    idle(3);

    // R7: three windows at distinct offsets
    tag = "R7";
    for (int k = 0; k < TP; k++) wr(2, k, rnd(400), rnd(400));
    en_m[0] = 1; en_m[1] = 1; en_m[2] = 1;
    off_m[0] = 3; off_m[1] = 10; off_m[2] = 20;
    for (int i = 0; i < 30; i++) send(rnd(500), rnd(500));
    idle(3);

    // R5: offset beyond the line end is clamped
    tag = "R5";
    en_m[0] = 0; en_m[1] = 0; en_m[2] = 1; off_m[2] = 63;
    for (int i = 0; i < 70; i++) send(rnd(600), rnd(600));
    off_m[2] = LEN - TP;
    for (int i = 0; i < 10; i++) send(rnd(600), rnd(600));
    idle(3);

    // R10: negated unity tap at offset 0 doubles the input
    tag = "R10";
    en_m[0] = 1; en_m[2] = 0; off_m[0] = 0;
    for (int k = 1; k < TP; k++) wr(0, k, 0, 0);
    wr(0, 0, -1024, 0);
    send(2047, -2048);
    send(-2048, 2047);
    send(1500, -1500);
    send(100, -100);
    idle(3);

    // R8: coefficient writes in the same cycle as streaming samples
    tag = "R8";
    off_m[0] = 1;
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) step(1, rnd(700), rnd(700), 1, 0, i % TP, rnd(1024), rnd(1024));
      else send(rnd(700), rnd(700));
    end
    idle(3);

    // R11: offsets and enables change on every sample, back to back
    tag = "R11";
    for (int i = 0; i < 24; i++) begin
      en_m[0] = (i % 2) == 0;
      en_m[1] = (i % 3) != 0;
      en_m[2] = 1;
      off_m[0] = i % 7;
      off_m[1] = (5 * i) % 50;
      off_m[2] = 40 + (i % 30);
      send(rnd(500), rnd(500));
    end
    idle(3);

    // R9: writes with illegal indices are ignored
    tag = "R9";
    wr(3, 0, 900, -900);
    wr(0, 5, 900, -900);
    wr(1, 7, -700, 700);
    en_m[0] = 1; en_m[1] = 1; en_m[2] = 1;
    off_m[0] = 0; off_m[1] = 2; off_m[2] = 6;
    for (int i = 0; i < 20; i++) send(rnd(500), rnd(500));
    idle(4);

    // R2: output holds between results
    hold_re = int'(out_re);
    hold_im = int'(out_im);
    idle(5);
    chk("R2", int'(out_re), hold_re, "hold out_re");
    chk("R2", int'(out_im), hold_im, "hold out_im");
    chk("R2", q_re.size(), 0, "pending results");
    finish_run();
  end
endmodule